// File: doc/BRIEF.md
# Four-Bit Accumulator Processor Core

This block is a compact 4-bit processor. It reads 8-bit instruction bytes from a synchronous ROM with a 12-bit address and executes them on a 4-bit accumulator, a carry flag and sixteen 4-bit index registers. Subroutine return addresses live in a rotating file of four 12-bit program counters. At any time one of the four counters drives the fetch address.

The ROM is read once per clock. The core presents an address in one cycle, and the byte comes back one cycle later. The core keeps fetching the next byte while it executes the current one. When the core redirects the fetch address, the byte already in flight is thrown away, so every taken redirect costs one bubble cycle. An external test input can be used as a branch condition. The accumulator and carry are brought out as ports, so a host or test harness can watch the results.

Top module: `acc4_core`

## Requirements
- R1: While reset is low, the fetch address, accumulator and carry are all zero. The first byte executed after reset is the byte at address 0.
- R2: Without a redirect, the fetch address rises by one each clock. Opcode 0x00, opcodes 0x01–0x0F, odd opcodes 0x21–0x2F, the whole 0xE0–0xEF range, 0xFC, 0xFD, 0xFE and 0xFF are all one-byte no-ops. They change neither the accumulator nor the carry.
- R3: 0xDn loads n into the accumulator. 0xAn copies register n into the accumulator. 0xBn swaps the accumulator with register n.
- R4: 0x2p with p even is a two-byte load of a register pair. Pair index p[3:1] selects the pair. The high nybble of the second byte goes to the even register and the low nybble to the odd register.
- R5: 0x8n sets {carry,acc} to acc + Rn + carry. 0x9n sets {carry,acc} to acc + ~Rn + ~carry, so a carry of 1 means no borrow.
- R6: 0x6n increments Rn and leaves carry alone. 0x7n is a two-byte op: it increments Rn, then jumps to the second byte if the result is nonzero, and otherwise falls through.
- R7: 0x1m is a two-byte conditional jump. Bit 1 of m tests acc==0, bit 2 tests carry==1 and bit 3 tests the test input. The selected tests are ORed together, and bit 0 of m inverts the result. A mask of 0 never jumps, and a mask of 1 always jumps.
- R8: 0x5h with second byte b calls {h,b}. The return address is held in the outgoing counter, and the active index advances modulo 4, so a fourth nested call overwrites the oldest return address. 0xCn steps back to the previous counter and loads n into the accumulator.
- R9: 0x3p with p odd jumps to the pair value within the page of the following byte. 0x3p with p even reads the ROM byte at {page, R0, R1} into pair p. Execution then resumes at the following byte.
- R10: 0xF0 clears the accumulator and carry. 0xF1 clears carry and 0xFA sets it. 0xF3 inverts carry and 0xF4 inverts the accumulator. 0xF2 increments and 0xF8 decrements the accumulator. The carry after a decrement is 1 when no borrow occurred.
- R11: 0xF5 and 0xF6 rotate the accumulator left and right through carry. 0xF7 moves carry into the accumulator and clears carry. 0xF9 loads 10 if carry is set, otherwise 9, and clears carry.
- R12: 0xFB adds 6 when acc>9 or carry=1. It sets carry on overflow and never clears it.
- R13: A taken jump presents its target on the clock after the second byte arrives, and the byte already fetched is discarded. Targets of 0x1m and 0x7n keep bits 11:8 of the address following the instruction, and 0x4h forms a full {h,b} target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_i | input | 1 | External branch condition |
| rom_addr_o | output | 12 | Fetch address to the synchronous ROM |
| rom_data_i | input | 8 | ROM byte for the address presented one cycle earlier |
| acc_o | output | 4 | Accumulator |
| carry_o | output | 1 | Carry flag |

## Verification
The assertions check these behaviours on every cycle:
- an immediate or return load reaches the accumulator on the next clock;
- a no-op advances the fetch address by exactly one;
- an unconditional jump presents its full 12-bit target on the next cycle;
- the carry-invert and increment operations treat carry correctly;
- decimal adjust never clears carry.

Some behaviour only shows across many instructions, and only the bench programs can demonstrate it. This covers the branch conditions and the page rule, the overwrite when the four-counter file wraps, the indirect ROM read, and the loop count of increment-and-skip.

// File: rtl/acc4_core.sv
module acc4_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        test_i,
  output logic [11:0] rom_addr_o,
  input  logic [7:0]  rom_data_i,
  output logic [3:0]  acc_o,
  output logic        carry_o
);
  typedef enum logic [2:0] {S_SKIP, S_RUN, S_ARG, S_FADR, S_FDAT} st_t;

  st_t         st;
  logic [11:0] pcs [4];
  logic [1:0]  sp;
  logic [3:0]  acc, regs [16];
  logic        carry;
  logic [7:0]  op;

  wire [7:0]  d      = rom_data_i;
  wire [11:0] pc     = pcs[sp];
  wire [3:0]  rn     = regs[d[3:0]];
  wire [3:0]  pr_hi  = regs[{d[3:1], 1'b0}];
  wire [3:0]  pr_lo  = regs[{d[3:1], 1'b1}];
  wire [4:0]  add_s  = {1'b0, acc} + {1'b0, rn} + {4'b0, carry};
  wire [4:0]  sub_s  = {1'b0, acc} + {1'b0, ~rn} + {4'b0, ~carry};
  wire [4:0]  daa_s  = {1'b0, acc} + 5'd6;
  wire [3:0]  isz_v  = regs[op[3:0]] + 4'd1;
  wire        cond   = (op[1] && acc == 4'd0) || (op[2] && carry) || (op[3] && test_i);
  wire        take   = cond ^ op[0];
  wire [11:0] fin_a  = {pc[11:8], regs[4'd0], regs[4'd1]};

  assign rom_addr_o = (st == S_FADR) ? fin_a : pc;
  assign acc_o      = acc;
  assign carry_o    = carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_SKIP;
      sp    <= 2'd0;
      acc   <= 4'd0;
      carry <= 1'b0;
      op    <= 8'h00;
      for (int i = 0; i < 4; i++)  pcs[i]  <= 12'd0;
      for (int i = 0; i < 16; i++) regs[i] <= 4'd0;
    end else begin
      case (st)
        S_SKIP: begin
          pcs[sp] <= pc + 12'd1;
          st      <= S_RUN;
        end
        S_FADR: st <= S_FDAT;
        S_FDAT: begin
          regs[{op[3:1], 1'b0}] <= d[7:4];
          regs[{op[3:1], 1'b1}] <= d[3:0];
          pcs[sp] <= pc + 12'd1;
          st      <= S_RUN;
        end
        S_ARG: begin
          pcs[sp] <= pc + 12'd1;
          st      <= S_RUN;
          case (op[7:4])
            4'h1: if (take) begin
              pcs[sp] <= {pc[11:8], d};
              st      <= S_SKIP;
            end
            4'h2: begin
              regs[{op[3:1], 1'b0}] <= d[7:4];
              regs[{op[3:1], 1'b1}] <= d[3:0];
            end
            4'h4: begin
              pcs[sp] <= {op[3:0], d};
              st      <= S_SKIP;
            end
            4'h5: begin
              pcs[sp]         <= pc;
              pcs[sp + 2'd1]  <= {op[3:0], d};
              sp              <= sp + 2'd1;
              st              <= S_SKIP;
            end
            4'h7: begin
              regs[op[3:0]] <= isz_v;
              if (isz_v != 4'd0) begin
                pcs[sp] <= {pc[11:8], d};
                st      <= S_SKIP;
              end
            end
            default: ;
          endcase
        end
        default: begin
          op      <= d;
          pcs[sp] <= pc + 12'd1;
          st      <= S_RUN;
          case (d[7:4])
            4'h1, 4'h4, 4'h5, 4'h7: st <= S_ARG;
            4'h2: if (!d[0]) st <= S_ARG;
            4'h3: if (d[0]) begin
              pcs[sp] <= {pc[11:8], pr_hi, pr_lo};
              st      <= S_SKIP;
            end else begin
              pcs[sp] <= pc;
              st      <= S_FADR;
            end
            4'h6: regs[d[3:0]] <= rn + 4'd1;
            4'h8: {carry, acc} <= add_s;
            4'h9: {carry, acc} <= sub_s;
            4'hA: acc <= rn;
            4'hB: begin
              acc           <= rn;
              regs[d[3:0]]  <= acc;
            end
            4'hC: begin
              sp  <= sp - 2'd1;
              acc <= d[3:0];
              st  <= S_SKIP;
            end
            4'hD: acc <= d[3:0];
            4'hF: case (d[3:0])
              4'h0: begin acc <= 4'd0; carry <= 1'b0; end
              4'h1: carry <= 1'b0;
              4'h2: {carry, acc} <= {1'b0, acc} + 5'd1;
              4'h3: carry <= ~carry;
              4'h4: acc <= ~acc;
              4'h5: {carry, acc} <= {acc, carry};
              4'h6: {acc, carry} <= {carry, acc};
              4'h7: begin acc <= {3'b0, carry}; carry <= 1'b0; end
              4'h8: {carry, acc} <= {1'b0, acc} + 5'h0F;
              4'h9: begin acc <= carry ? 4'hA : 4'h9; carry <= 1'b0; end
              4'hA: carry <= 1'b1;
              4'hB: if (acc > 4'd9 || carry) begin
                acc <= daa_s[3:0];
                if (daa_s[4]) carry <= 1'b1;
              end
              default: ;
            endcase
            default: ;
          endcase
        end
      endcase
    end
  end

  // R3
  ldm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && d[7:4] == 4'hD) |=> acc_o == $past(rom_data_i[3:0]));

  // R8
  bbl_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && d[7:4] == 4'hC) |=> (acc_o == $past(rom_data_i[3:0]) && st == S_SKIP));

  // R2
  nop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && d == 8'h00) |=> rom_addr_o == $past(rom_addr_o) + 12'd1);

  // R13
  jun_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARG && op[7:4] == 4'h4) |=> rom_addr_o == {$past(op[3:0]), $past(rom_data_i)});

  // R10
  cmc_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && d == 8'hF3) |=> carry_o != $past(carry_o));

  // R6
  inc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && d[7:4] == 4'h6) |=> carry_o == $past(carry_o));

  // R12
  daa_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && d == 8'hFB && carry_o) |=> carry_o);
endmodule

// File: tb/test_acc4_core.sv
`timescale 1ns/1ps
module test_acc4_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        test_i = 1'b0;
  logic [11:0] rom_addr;
  logic [7:0]  rom_q;
  logic [3:0]  acc;
  logic        carry;
  logic [7:0]  rom [512];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;
  always @(posedge clk) rom_q <= rom[rom_addr[8:0]];

  acc4_core i_acc4_core (
    .clk(clk), .rst_n(rst_n), .test_i(test_i), .rom_addr_o(rom_addr),
    .rom_data_i(rom_q), .acc_o(acc), .carry_o(carry)
  );

  // {six program bytes, expected acc, expected carry, test input, requirement}
  localparam int NV = 33;
  localparam logic [57:0] VEC [NV] = '{
    {48'hD7B3D2A30000, 4'h7, 1'b0, 1'b0, 4'd3},   // R3
    {48'h24A5A4000000, 4'hA, 1'b0, 1'b0, 4'd4},   // R4
    {48'h263CA7000000, 4'hC, 1'b0, 1'b0, 4'd4},   // R4
    {48'hD9B1D8810000, 4'h1, 1'b1, 1'b0, 4'd5},   // R5
    {48'hFAD3B2D48200, 4'h8, 1'b0, 1'b0, 4'd5},   // R5
    {48'hD3B1D5910000, 4'h2, 1'b1, 1'b0, 4'd5},   // R5
    {48'hD5B1D3910000, 4'hE, 1'b0, 1'b0, 4'd5},   // R5
    {48'hFA6060A00000, 4'h2, 1'b1, 1'b0, 4'd6},   // R6
    {48'hF27D00000000, 4'h0, 1'b1, 1'b0, 4'd6},   // R6
    {48'h1205D94006D3, 4'h3, 1'b0, 1'b0, 4'd7},   // R7
    {48'h1305D94006D3, 4'h9, 1'b0, 1'b0, 4'd7},   // R7
    {48'h1805D94006D3, 4'h3, 1'b0, 1'b1, 4'd7},   // R7
    {48'h1005D94006D3, 4'h9, 1'b0, 1'b1, 4'd7},   // R7
    {48'h1105D94006D3, 4'h3, 1'b0, 1'b0, 4'd7},   // R7
    {48'hFA1406D94006, 4'h0, 1'b1, 1'b0, 4'd7},   // R7
    {48'hD4E005FEFF21, 4'h4, 1'b0, 1'b0, 4'd2},   // R2
    {48'hD4FCFDE3E7EF, 4'h4, 1'b0, 1'b0, 4'd2},   // R2
    {48'hD5F4F3000000, 4'hA, 1'b1, 1'b0, 4'd10},  // R10
    {48'hD7FAF0000000, 4'h0, 1'b0, 1'b0, 4'd10},  // R10
    {48'hFAF1D3000000, 4'h3, 1'b0, 1'b0, 4'd10},  // R10
    {48'hDFF200000000, 4'h0, 1'b1, 1'b0, 4'd10},  // R10
    {48'hD0F800000000, 4'hF, 1'b0, 1'b0, 4'd10},  // R10
    {48'hD1F800000000, 4'h0, 1'b1, 1'b0, 4'd10},  // R10
    {48'hFAD9F5000000, 4'h3, 1'b1, 1'b0, 4'd11},  // R11
    {48'hD6FAF6000000, 4'hB, 1'b0, 1'b0, 4'd11},  // R11
    {48'hFAF700000000, 4'h1, 1'b0, 1'b0, 4'd11},  // R11
    {48'hFAF900000000, 4'hA, 1'b0, 1'b0, 4'd11},  // R11
    {48'hF90000000000, 4'h9, 1'b0, 1'b0, 4'd11},  // R11
    {48'hDBFB00000000, 4'h1, 1'b1, 1'b0, 4'd12},  // R12
    {48'hD5FAFB000000, 4'hB, 1'b1, 1'b0, 4'd12},  // R12
    {48'hD3FB00000000, 4'h3, 1'b0, 1'b0, 4'd12},  // R12
    {48'h200631D90000, 4'h0, 1'b0, 1'b0, 4'd9},   // R9
    {48'h200730A10000, 4'h6, 1'b0, 1'b0, 4'd9}    // R9
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 512; i++) rom[i] = 8'h00;
  endtask

  // R1: reset state, then release on a falling edge
  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(rom_addr == 12'd0 && acc == 4'd0 && carry == 1'b0, "R1", "reset state",
          {rom_addr, acc, 3'b0, carry}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_and_check(input string req, input logic [3:0] ea, input logic ec);
    repeat (150) @(posedge clk);
    @(negedge clk);
    check(acc == ea && carry == ec, req, "acc/carry", {acc, carry}, {ea, ec});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_rom();
    for (int v = 0; v < NV; v++) begin
      logic [57:0] e;
      e = VEC[v];
      clear_rom();
      for (int b = 0; b < 6; b++) rom[b] = e[57 - 8*b -: 8];
      rom[6] = 8'h40;
      rom[7] = 8'h06;
      test_i = e[4];
      do_reset();
      run_and_check($sformatf("R%0d", e[3:0]), e[9:6], e[5]);
    end
    test_i = 1'b0;

    // R2: sequential fetch over NOPs
    clear_rom();
    do_reset();
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(rom_addr == 12'(k), "R2", "sequential address", rom_addr, k);
    end

    // R13: redirect timing with one discarded byte
    clear_rom();
    rom[0] = 8'h40; rom[1] = 8'h05;
    do_reset();
    begin
      int exp_a [4] = '{1, 2, 5, 6};
      for (int k = 0; k < 4; k++) begin
        @(posedge clk);
        @(negedge clk);
        check(rom_addr == 12'(exp_a[k]), "R13", "jump timing", rom_addr, exp_a[k]);
      end
    end

    // R13: conditional target keeps the page of the following byte
    clear_rom();
    rom[0] = 8'hFA; rom[1] = 8'h40; rom[2] = 8'hFE;
    rom[9'h0FE] = 8'h14; rom[9'h0FF] = 8'h20;
    rom[9'h120] = 8'hD7; rom[9'h121] = 8'h41; rom[9'h122] = 8'h21;
    do_reset();
    run_and_check("R13", 4'h7, 1'b1);

    // R8: call and return
    clear_rom();
    rom[0] = 8'h50; rom[1] = 8'h10; rom[2] = 8'hF2; rom[3] = 8'h40; rom[4] = 8'h03;
    rom[16] = 8'hC6;
    do_reset();
    run_and_check("R8", 4'h7, 1'b0);

    // R8: fourth nested call overwrites the oldest return address
    clear_rom();
    rom[0] = 8'h50;  rom[1] = 8'h20;
    rom[2] = 8'hD2;  rom[3] = 8'h40;  rom[4] = 8'h03;
    rom[8'h20] = 8'h50; rom[8'h21] = 8'h30; rom[8'h22] = 8'hC4;
    rom[8'h30] = 8'h50; rom[8'h31] = 8'h40; rom[8'h32] = 8'hC3;
    rom[8'h40] = 8'h50; rom[8'h41] = 8'h50; rom[8'h42] = 8'hC2;
    rom[8'h50] = 8'h14; rom[8'h51] = 8'h58; rom[8'h52] = 8'hFA; rom[8'h53] = 8'hC1;
    rom[8'h58] = 8'hD8; rom[8'h59] = 8'h40; rom[8'h5A] = 8'h59;
    do_reset();
    run_and_check("R8", 4'h8, 1'b1);

    // R1: reset in the middle of a run clears state again
    clear_rom();
    rom[0] = 8'hFA; rom[1] = 8'hD9;
    do_reset();
    repeat (10) @(posedge clk);
    do_reset();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule